// File: doc/BRIEF.md
# Two-Input Parity Check Message Approximator

This unit forms the outgoing soft message of a single parity check node from two signed fixed-point incoming messages. Its base term is the smaller of the two input magnitudes, with the sign chosen so that the parity condition holds. Added to it is a cheap piecewise-linear correction that brings the result closer to the exact check-node function. The correction is the difference of one clipped ramp evaluated at the magnitude of the sum and at the magnitude of the difference of the inputs.

Each accepted input pair produces one result a single clock later. A check with more than two inputs is handled by feeding a result back as one input of the next pass, so that three inputs are combined as f(x, f(y, z)). Messages are two's complement with `FRAC_W` fractional bits (default 3). The ramp offset of 5/8 is then an exact code, and division by four is a right shift.

Top module: `spc_msg_approx`

## Requirements
- R1: During reset and after it, until the first accepted pair, `out_valid` is 0 and `out_msg` is 0.
- R2: `out_valid` in each cycle equals the value of `in_valid` at the previous rising clock edge, so every accepted pair yields its result exactly one cycle later.
- R3: When `in_valid` is 0 at a rising edge, `out_msg` keeps its previous value, whatever `in_a` and `in_b` carry.
- R4: The result is negative exactly when one input is negative and the other is not (a negative input has its MSB set). Its base magnitude is min(|a|, |b|). When |a+b| and |a-b| are both at least 5/2 (code 20 at 3 fractional bits), the result equals this signed minimum.
- R5: The ramp is psi(v) = max(5/8 - floor(v/4), 0) in message codes, with floor taken on the raw code (v is nonnegative). At 3 fractional bits: psi(v) = max(5 - floor(v/4), 0).
- R6: The result is the signed minimum plus psi(|a+b|) - psi(|a-b|). With equal inputs the second ramp takes its peak value 5/8.
- R7: An input holding the most negative code is treated as having the largest positive magnitude, 2^(MSG_W-1)-1.
- R8: The result is saturated to the symmetric range of plus or minus 2^(MSG_W-1)-1, and the most negative code never appears on `out_msg` while `out_valid` is 1.
- R9: Codes are two's complement with FRAC_W fractional bits. At the default of 3, inputs 1.0 and 1.0 (codes 8, 8) give 0.5 (code 4).
- R10: A result fed back as an input combines three messages serially: driving (y, z) and then (x, result) gives f(x, f(y, z)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input pair in this cycle |
| in_a | input | MSG_W | First incoming message, signed |
| in_b | input | MSG_W | Second incoming message, signed |
| out_valid | output | 1 | Result on `out_msg` is new in this cycle |
| out_msg | output | MSG_W | Outgoing message, signed, held between results |

## Verification
Every cycle, the assertions check the one-cycle valid delay, the hold of the output when no pair arrives, the exclusion of the most negative output code, and the peak of the difference ramp whenever the two inputs are equal. Only the bench's scenarios can show the arithmetic itself. Those scenarios cover sign selection, the minimum, the floor inside the ramp, the correction sign for like and unlike input signs, the treatment of the most negative code, and a serial three-input combination that depends on the registered result being fed back correctly.

// File: rtl/spc_pkg.sv
package spc_pkg;
    // Ramp offset 5/8 expressed in eighths, and the fraction width it is exact at
    localparam int PSI_OFS_EIGHTHS = 5;
    localparam int PSI_BASE_FRAC   = 3;
    // Ramp slope 1/4 realised as a right shift
    localparam int PSI_SLOPE_SHIFT = 2;
endpackage

// File: rtl/spc_abs.sv
module spc_abs #(
    parameter int IN_W     = 8,
    parameter bit SATURATE = 1'b1,
    parameter int OUT_W    = SATURATE ? IN_W - 1 : IN_W
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic [OUT_W-1:0]       mag_o
);
    localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};

    generate
        if (SATURATE) begin : g_sat
            // Most negative code folds onto the largest positive magnitude
            always_comb begin
                if (val_i == MOST_NEG)
                    mag_o = '1;
                else if (val_i[IN_W-1])
                    mag_o = OUT_W'(-val_i);
                else
                    mag_o = OUT_W'(val_i);
            end
        end else begin : g_wide
            // Output is as wide as the input, so every magnitude fits
            always_comb begin
                if (val_i[IN_W-1])
                    mag_o = OUT_W'(-val_i);
                else
                    mag_o = OUT_W'(val_i);
            end
        end
    endgenerate
endmodule

// File: rtl/spc_psi.sv
module spc_psi #(
    parameter int A_W    = 9,
    parameter int FRAC_W = 3
) (
    input  logic [A_W-1:0]    a_i,
    output logic [FRAC_W-1:0] psi_o
);
    localparam int OFS = spc_pkg::PSI_OFS_EIGHTHS << (FRAC_W - spc_pkg::PSI_BASE_FRAC);
    localparam logic [A_W-1:0] OFS_EXT = A_W'(OFS);

    logic [A_W-1:0] quarter;

    always_comb begin
        quarter = a_i >> spc_pkg::PSI_SLOPE_SHIFT;
        if (quarter < OFS_EXT)
            psi_o = FRAC_W'(OFS_EXT - quarter);
        else
            psi_o = '0;
    end
endmodule

// File: rtl/spc_combine.sv
module spc_combine #(
    parameter int MSG_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic [MSG_W-2:0]         mag_a_i,
    input  logic [MSG_W-2:0]         mag_b_i,
    input  logic                     sign_a_i,
    input  logic                     sign_b_i,
    input  logic [FRAC_W-1:0]        psi_add_i,
    input  logic [FRAC_W-1:0]        psi_sub_i,
    output logic signed [MSG_W-1:0]  msg_o
);
    localparam int EXT_W = MSG_W + 2;
    localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((2 ** (MSG_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

    logic [MSG_W-2:0]         min_mag;
    logic                     neg;
    logic signed [EXT_W-1:0]  base;
    logic signed [EXT_W-1:0]  corr;
    logic signed [EXT_W-1:0]  total;

    always_comb begin
        min_mag = (mag_a_i < mag_b_i) ? mag_a_i : mag_b_i;
        neg     = sign_a_i ^ sign_b_i;
        base    = neg ? -$signed(EXT_W'(min_mag)) : $signed(EXT_W'(min_mag));
        corr    = $signed(EXT_W'(psi_add_i)) - $signed(EXT_W'(psi_sub_i));
        total   = base + corr;
        if (total > POS_LIM)
            msg_o = MSG_W'(POS_LIM);
        else if (total < NEG_LIM)
            msg_o = MSG_W'(NEG_LIM);
        else
            msg_o = MSG_W'(total);
    end
endmodule

// File: rtl/spc_msg_approx.sv
module spc_msg_approx #(
    parameter int MSG_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [MSG_W-1:0]  in_a,
    input  logic signed [MSG_W-1:0]  in_b,
    output logic                     out_valid,
    output logic signed [MSG_W-1:0]  out_msg
);
    localparam int SUM_W = MSG_W + 1;
    localparam int MAG_W = MSG_W - 1;
    localparam logic [FRAC_W-1:0] PSI_PEAK =
        FRAC_W'(spc_pkg::PSI_OFS_EIGHTHS << (FRAC_W - spc_pkg::PSI_BASE_FRAC));
    localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {(MSG_W-1){1'b0}}};

    logic [MAG_W-1:0]         mag_a;
    logic [MAG_W-1:0]         mag_b;
    logic signed [SUM_W-1:0]  sum_c;
    logic signed [SUM_W-1:0]  dif_c;
    logic [SUM_W-1:0]         sum_mag;
    logic [SUM_W-1:0]         dif_mag;
    logic [FRAC_W-1:0]        psi_sum;
    logic [FRAC_W-1:0]        psi_dif;
    logic signed [MSG_W-1:0]  msg_c;

    // Saturating magnitudes of each input feed the minimum
    spc_abs #(.IN_W(MSG_W), .SATURATE(1'b1), .OUT_W(MAG_W)) u_abs_a (
        .val_i (in_a),
        .mag_o (mag_a)
    );
    spc_abs #(.IN_W(MSG_W), .SATURATE(1'b1), .OUT_W(MAG_W)) u_abs_b (
        .val_i (in_b),
        .mag_o (mag_b)
    );

    // Sum and difference one bit wider so neither can wrap
    always_comb begin
        sum_c = $signed({in_a[MSG_W-1], in_a}) + $signed({in_b[MSG_W-1], in_b});
        dif_c = $signed({in_a[MSG_W-1], in_a}) - $signed({in_b[MSG_W-1], in_b});
    end

    spc_abs #(.IN_W(SUM_W), .SATURATE(1'b0), .OUT_W(SUM_W)) u_abs_sum (
        .val_i (sum_c),
        .mag_o (sum_mag)
    );
    spc_abs #(.IN_W(SUM_W), .SATURATE(1'b0), .OUT_W(SUM_W)) u_abs_dif (
        .val_i (dif_c),
        .mag_o (dif_mag)
    );

    spc_psi #(.A_W(SUM_W), .FRAC_W(FRAC_W)) u_psi_sum (
        .a_i   (sum_mag),
        .psi_o (psi_sum)
    );
    spc_psi #(.A_W(SUM_W), .FRAC_W(FRAC_W)) u_psi_dif (
        .a_i   (dif_mag),
        .psi_o (psi_dif)
    );

    spc_combine #(.MSG_W(MSG_W), .FRAC_W(FRAC_W)) u_combine (
        .mag_a_i   (mag_a),
        .mag_b_i   (mag_b),
        .sign_a_i  (in_a[MSG_W-1]),
        .sign_b_i  (in_b[MSG_W-1]),
        .psi_add_i (psi_sum),
        .psi_sub_i (psi_dif),
        .msg_o     (msg_c)
    );

    // Single output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_msg <= msg_c;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_msg)); // R3
    AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_msg != MOST_NEG)); // R8
    AST_EQUAL_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a == in_b)) |-> (psi_dif == PSI_PEAK)); // R6
endmodule

// File: tb/spc_msg_approx_tb.sv
module spc_msg_approx_tb;
    localparam int W    = 8;
    localparam int FRAC = 3;
    localparam int MAXV = (2 ** (W - 1)) - 1;
    localparam int MINV = -(2 ** (W - 1));
    localparam int OFS  = 5 << (FRAC - 3);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_a = '0;
    logic signed [W-1:0]  in_b = '0;
    logic                 out_valid;
    logic signed [W-1:0]  out_msg;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    q_exp[$];
    string q_tag[$];
    logic  prev_iv = 1'b0;
    int    last_out = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    spc_msg_approx #(.MSG_W(W), .FRAC_W(FRAC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_msg   (out_msg)
    );

    function automatic int psi_ref(int v);
        int r;
        r = OFS - (v / 4);
        return (r > 0) ? r : 0;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int model(int a, int b);
        int ma, mb, mn, t;
        ma = (a == MINV) ? MAXV : iabs(a);
        mb = (b == MINV) ? MAXV : iabs(b);
        mn = (ma < mb) ? ma : mb;
        t  = (((a < 0) != (b < 0)) ? -mn : mn) + psi_ref(iabs(a + b)) - psi_ref(iabs(a - b));
        if (t > MAXV) t = MAXV;
        if (t < -MAXV) t = -MAXV;
        return t;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: applies one pair and queues its expected result
    task automatic send(int a, int b, int exp, string tag);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_a = W'(a);
        in_b = W'(b);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_a = W'(37 * i - 90);
            in_b = W'(-53 * i + 11);
        end
    endtask

    // Monitor: checks valid timing, hold, range, and pops the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 valid delay", int'(out_valid), int'(prev_iv));
            if (out_valid) begin
                check("R8 never most negative", int'(out_msg == W'(MINV)), 0);
                if (q_exp.size() == 0) begin
                    check("R2 unexpected result", 1, 0);
                end else begin
                    check(q_tag.pop_front(), int'(out_msg), q_exp.pop_front());
                end
                last_out = int'(out_msg);
            end else begin
                check("R3 hold without valid", int'(out_msg), last_out);
            end
            prev_iv = in_valid;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset msg", int'(out_msg), 0);
        rst_n = 1'b1;
        idle(3);
        #1;
        check("R1 after reset valid", int'(out_valid), 0);
        check("R1 after reset msg", int'(out_msg), 0);

        send(8, 8, 4, "R9 one and one");
        send(8, -8, -4, "R6 unlike signs correction");
        send(16, 16, 11, "R6 equal inputs peak");
        send(-40, -64, 40, "R4 both negative");
        send(40, -64, -40, "R4 unlike signs far");
        send(40, -24, -23, "R4 R6 sign with correction");
        send(9, 2, 1, "R5 floor of quarter");
        send(6, 1, 1, "R5 ramps cancel");
        send(-128, -128, 122, "R7 most negative pair");
        send(-128, 40, -40, "R7 most negative against small");
        send(127, 127, 122, "R8 largest positive pair");
        idle(4);
        send(20, -30, model(20, -30), "R2 after idle");
        idle(2);

        for (int a = MINV; a <= MAXV; a += 17) begin
            for (int b = MINV; b <= MAXV; b += 23) begin
                send(a, b, model(a, b), "R4 R6 sweep");
            end
            idle(1);
        end
        idle(3);

        // Serial three-input combination through the result port
        for (int k = 0; k < 6; k++) begin
            int x, y, z;
            x = 11 * k - 30;
            y = -7 * k + 19;
            z = 5 * k - 12;
            send(y, z, model(y, z), "R10 first pass");
            idle(1);
            @(negedge clk);
            r = int'(out_msg);
            check("R10 inner result", r, model(y, z));
            send(x, r, model(x, model(y, z)), "R10 second pass");
            idle(2);
        end

        idle(4);
        check("R2 scoreboard drained", q_exp.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule